// File: doc/BRIEF.md
# Multi-Queue Pipe Context Switcher

This block controls one execution pipe that holds several hardware queue slots. Each slot keeps a descriptor image of `DW` 32-bit words in registers. A backing memory keeps one saved copy of each queue's descriptor. The pipe works on exactly one queue at a time. The controller decides which mapped queue runs next and carries out the whole hand-over sequence: it drops the outgoing queue's active bit, waits for the pipe to drain, writes the outgoing descriptor to memory, reads the incoming descriptor back into its slot, and only then raises the new queue's active bit. A chip with several pipes instantiates the block once per pipe, and each instance sets its own queue count.

Three events can request a switch: a command-stream boundary, a packet boundary (honoured only while packet-granular switching is enabled), and a request from an external scheduler. The next queue is picked round-robin among mapped queues, starting at the slot after the current one. A request that arrives while a switch is already under way is remembered and acted on as soon as the pipe runs again. The save area has a fixed layout. Queue `q`, word `w` sits at address `q*DW + w`. Word 1 is the count of packets consumed, which the block advances on every packet boundary while the queue runs. The remaining words hold the ring base, the save-area pointer, the doorbell index and the rest of the register image, and the block moves them unchanged.

The memory port is a single valid/ready request channel. A request holds `mem_req_valid`, `mem_req_we`, `mem_req_addr` and `mem_req_wdata` steady until `mem_req_ready` accepts it. Exactly one word moves per accepted request. A read returns its word on `mem_rsp_valid`/`mem_rsp_rdata` in the cycle after it is accepted. The response channel has no back-pressure, because the block always accepts read data.

Top module: `ctxsw_pipe`

## Requirements
- R1: At most one bit of `q_active` is set at any time; while `run_valid` is high exactly one bit is set, and it is the bit selected by `run_queue`.
- R2: A queue whose `map_mask` bit is low is never activated; with no queue mapped the block stays idle with `run_valid` low and `q_active` all zero.
- R3: In the running state a pulse on `sw_stream` or `sw_sched` starts a switch; a pulse on `pkt_boundary` starts a switch only while `pkt_sw_en` is high.
- R4: On a switch the outgoing queue's active bit is cleared first; no save write is issued until that bit reads low and `pipe_idle` is high.
- R5: A restore reads words 0 to DW-1 from addresses `q*DW + w` into the incoming queue's descriptor; no active bit is set while any restore read is outstanding, and once the queue runs, `run_desc` (word `w` at bits `w*32`) equals the restored image.
- R6: Each `pkt_boundary` pulse seen while running increments descriptor word 1 of the running queue by one.
- R7: A save writes all DW words of the outgoing descriptor, word `w` to address `q*DW + w`, including the updated word 1.
- R8: The next queue is the first mapped queue found scanning upward from the current one with wrap-around, skipping unmapped slots.
- R9: When a switch is requested and no other queue is mapped, the current queue keeps running and no save write occurs.
- R10: A switch request that arrives outside the running state is held and causes one switch right after the pipe runs again.
- R11: A synchronous active-high `rst` leaves `run_valid` low, `q_active` zero and `mem_req_valid` low; the first activation then picks queue 0 if it is mapped.
- R12: Clearing the running queue's `map_mask` bit forces a save of it; the pipe then restores the next mapped queue, or goes idle if none is mapped.
- R13: A memory request held without `mem_req_ready` keeps its valid, address, direction and data stable; `switch_done` is a one-cycle pulse in the first running cycle of each newly activated queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_mask | input | NQ | Per-queue mapped flags |
| sw_stream | input | 1 | Command-stream boundary switch request (pulse) |
| sw_sched | input | 1 | External scheduler switch request (pulse) |
| pkt_boundary | input | 1 | Packet completed by the running queue (pulse) |
| pkt_sw_en | input | 1 | Treat every packet boundary as a switch request |
| pipe_idle | input | 1 | Pipe has drained outstanding work |
| mem_req_valid | output | 1 | Save-area request valid |
| mem_req_ready | input | 1 | Save-area request accepted |
| mem_req_we | output | 1 | 1 = write (save), 0 = read (restore) |
| mem_req_addr | output | AW | Word address `q*DW + w` |
| mem_req_wdata | output | XW | Write data |
| mem_rsp_valid | input | 1 | Read data valid, one cycle after read acceptance |
| mem_rsp_rdata | input | XW | Read data |
| run_valid | output | 1 | Pipe is running a queue |
| run_queue | output | QW | Index of the current queue |
| run_desc | output | DW*XW | Descriptor image of the current queue |
| q_active | output | NQ | Per-queue active bits |
| switch_done | output | 1 | One-cycle pulse when a newly activated queue starts running |

## Verification
Directed cases cover the corner cases. With only one queue mapped, the bench tells a dropped request from a spurious save. With `pipe_idle` held low, a save that waits for the drain can be told from one that starts early. Toggling `pkt_sw_en` around packet pulses shows that the packet trigger is gated. A second request sent during a switch must not be lost. Unmapping the running queue, first with a successor and then with none, separates a forced switch from a forced idle. Constrained-random traffic then mixes scheduler requests, packet pulses, a stalling memory and a wandering drain signal. On every switch the bench checks the round-robin successor and the saved and restored packet counters against its own tallies.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;
  typedef enum logic [2:0] {
    CS_IDLE,
    CS_RUN,
    CS_DEACT,
    CS_WAIT_INACT,
    CS_SAVE,
    CS_RESTORE,
    CS_ACTIVATE
  } cs_state_t;

  // descriptor word that counts consumed packets
  localparam int W_PKTCNT = 1;
endpackage

// File: rtl/ctxsw_rr_pick.sv
module ctxsw_rr_pick #(
  parameter int NQ = 2,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic [NQ-1:0] mask,
  input  logic [QW-1:0] base,
  input  logic          skip_base,
  output logic          found,
  output logic [QW-1:0] pick
);
  always_comb begin
    found = 1'b0;
    pick  = base;
    for (int k = 1; k <= NQ; k++) begin
      logic [QW:0] sum;
      logic [QW-1:0] cand;
      sum = {1'b0, base} + (QW+1)'(k);
      if (sum >= (QW+1)'(NQ)) sum = sum - (QW+1)'(NQ);
      cand = sum[QW-1:0];
      if (!found && mask[cand] && !(skip_base && cand == base)) begin
        found = 1'b1;
        pick  = cand;
      end
    end
  end
endmodule

// File: rtl/ctxsw_desc_bank.sv
module ctxsw_desc_bank
  import ctxsw_pkg::*;
#(
  parameter int NQ = 2,
  parameter int DW = 8,
  parameter int XW = 32,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int IW = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [QW-1:0]    wr_q,
  input  logic [IW-1:0]    wr_idx,
  input  logic [XW-1:0]    wr_data,
  input  logic             inc_en,
  input  logic [QW-1:0]    inc_q,
  input  logic [QW-1:0]    rd_q,
  input  logic [IW-1:0]    rd_idx,
  output logic [XW-1:0]    rd_word,
  input  logic [QW-1:0]    view_q,
  output logic [DW*XW-1:0] view_desc
);
  logic [DW*XW-1:0] img [NQ];

  for (genvar g = 0; g < NQ; g++) begin : g_slot
    logic [XW-1:0]    word_q [DW];
    logic [DW*XW-1:0] flat;

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < DW; i++) word_q[i] <= '0;
      end else begin
        if (wr_en && wr_q == QW'(g)) word_q[wr_idx] <= wr_data;
        if (inc_en && inc_q == QW'(g))
          word_q[W_PKTCNT] <= word_q[W_PKTCNT] + XW'(1);
      end
    end

    always_comb begin
      for (int i = 0; i < DW; i++) flat[i*XW +: XW] = word_q[i];
    end

    assign img[g] = flat;
  end

  assign rd_word   = img[rd_q][int'(rd_idx)*XW +: XW];
  assign view_desc = img[view_q];
endmodule

// File: rtl/ctxsw_xfer.sv
module ctxsw_xfer #(
  parameter int NQ = 2,
  parameter int DW = 8,
  parameter int XW = 32,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int IW = $clog2(DW),
  localparam int AW = $clog2(NQ*DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_save,
  input  logic [QW-1:0] start_q,
  output logic          done,
  output logic [QW-1:0] bank_q,
  output logic [IW-1:0] bank_rd_idx,
  input  logic [XW-1:0] bank_rd_word,
  output logic          bank_wr_en,
  output logic [IW-1:0] bank_wr_idx,
  output logic [XW-1:0] bank_wr_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [XW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [XW-1:0] mem_rsp_rdata
);
  localparam logic [IW:0] LAST = (IW+1)'(DW);

  logic          busy, save_dir;
  logic [QW-1:0] cur_q;
  logic [IW:0]   issued, recvd;
  logic          fire;

  assign mem_req_valid = busy && (issued != LAST);
  assign mem_req_we    = save_dir;
  assign mem_req_addr  = AW'(int'(cur_q) * DW + int'(issued));
  assign mem_req_wdata = bank_rd_word;
  assign fire          = mem_req_valid && mem_req_ready;

  assign bank_q       = cur_q;
  assign bank_rd_idx  = issued[IW-1:0];
  assign bank_wr_en   = busy && !save_dir && mem_rsp_valid;
  assign bank_wr_idx  = recvd[IW-1:0];
  assign bank_wr_data = mem_rsp_rdata;

  assign done = busy && (save_dir ? (issued == LAST) : (recvd == LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      save_dir <= 1'b0;
      cur_q    <= '0;
      issued   <= '0;
      recvd    <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      save_dir <= start_save;
      cur_q    <= start_q;
      issued   <= '0;
      recvd    <= '0;
    end else if (done) begin
      busy <= 1'b0;
    end else begin
      if (fire)       issued <= issued + 1'b1;
      if (bank_wr_en) recvd  <= recvd + 1'b1;
    end
  end

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  // R13
  rsp_expected_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid |-> busy && !save_dir);

  // R5
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy || done);
endmodule

// File: rtl/ctxsw_pipe.sv
module ctxsw_pipe
  import ctxsw_pkg::*;
#(
  parameter int NQ = 2,
  parameter int DW = 8,
  parameter int XW = 32,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int IW = $clog2(DW),
  localparam int AW = $clog2(NQ*DW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NQ-1:0]    map_mask,
  input  logic             sw_stream,
  input  logic             sw_sched,
  input  logic             pkt_boundary,
  input  logic             pkt_sw_en,
  input  logic             pipe_idle,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_we,
  output logic [AW-1:0]    mem_req_addr,
  output logic [XW-1:0]    mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [XW-1:0]    mem_rsp_rdata,
  output logic             run_valid,
  output logic [QW-1:0]    run_queue,
  output logic [DW*XW-1:0] run_desc,
  output logic [NQ-1:0]    q_active,
  output logic             switch_done
);
  cs_state_t     state;
  logic [QW-1:0] cur_q, nxt_q;
  logic          pend;

  logic          req_now, req_any;
  logic          arb_found;
  logic [QW-1:0] arb_pick;
  logic          xf_start, xf_save, xf_done;
  logic [QW-1:0] xf_q;

  logic          bk_wr_en;
  logic [QW-1:0] bk_q;
  logic [IW-1:0] bk_rd_idx, bk_wr_idx;
  logic [XW-1:0] bk_rd_word, bk_wr_data;

  assign req_now = sw_stream | sw_sched | (pkt_boundary & pkt_sw_en);
  assign req_any = req_now | pend;

  ctxsw_rr_pick #(.NQ(NQ)) u_pick (
    .mask      (map_mask),
    .base      (cur_q),
    .skip_base (state == CS_RUN),
    .found     (arb_found),
    .pick      (arb_pick)
  );

  assign xf_save  = (state == CS_WAIT_INACT);
  assign xf_start = (state == CS_IDLE && arb_found)
                 || (xf_save && !q_active[cur_q] && pipe_idle)
                 || (state == CS_SAVE && xf_done && arb_found);
  assign xf_q     = xf_save ? cur_q : arb_pick;

  ctxsw_xfer #(.NQ(NQ), .DW(DW), .XW(XW)) u_xfer (
    .clk           (clk),
    .rst           (rst),
    .start         (xf_start),
    .start_save    (xf_save),
    .start_q       (xf_q),
    .done          (xf_done),
    .bank_q        (bk_q),
    .bank_rd_idx   (bk_rd_idx),
    .bank_rd_word  (bk_rd_word),
    .bank_wr_en    (bk_wr_en),
    .bank_wr_idx   (bk_wr_idx),
    .bank_wr_data  (bk_wr_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata)
  );

  ctxsw_desc_bank #(.NQ(NQ), .DW(DW), .XW(XW)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bk_wr_en),
    .wr_q      (bk_q),
    .wr_idx    (bk_wr_idx),
    .wr_data   (bk_wr_data),
    .inc_en    (state == CS_RUN && pkt_boundary),
    .inc_q     (cur_q),
    .rd_q      (bk_q),
    .rd_idx    (bk_rd_idx),
    .rd_word   (bk_rd_word),
    .view_q    (cur_q),
    .view_desc (run_desc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= CS_IDLE;
      cur_q       <= QW'(NQ-1);
      nxt_q       <= '0;
      q_active    <= '0;
      pend        <= 1'b0;
      switch_done <= 1'b0;
    end else begin
      switch_done <= 1'b0;
      if (state != CS_RUN && req_now) pend <= 1'b1;
      case (state)
        CS_IDLE: begin
          if (arb_found) begin
            nxt_q <= arb_pick;
            state <= CS_RESTORE;
          end
        end
        CS_RUN: begin
          pend <= 1'b0;
          if (!map_mask[cur_q] || (req_any && arb_found)) state <= CS_DEACT;
        end
        CS_DEACT: begin
          q_active[cur_q] <= 1'b0;
          state           <= CS_WAIT_INACT;
        end
        CS_WAIT_INACT: begin
          if (!q_active[cur_q] && pipe_idle) state <= CS_SAVE;
        end
        CS_SAVE: begin
          if (xf_done) begin
            if (arb_found) begin
              nxt_q <= arb_pick;
              state <= CS_RESTORE;
            end else begin
              state <= CS_IDLE;
            end
          end
        end
        CS_RESTORE: begin
          if (xf_done) state <= CS_ACTIVATE;
        end
        CS_ACTIVATE: begin
          if (map_mask[nxt_q]) begin
            q_active[nxt_q] <= 1'b1;
            cur_q           <= nxt_q;
            switch_done     <= 1'b1;
            state           <= CS_RUN;
          end else begin
            state <= CS_IDLE;
          end
        end
        default: state <= CS_IDLE;
      endcase
    end
  end

  assign run_valid = (state == CS_RUN);
  assign run_queue = cur_q;

  // R1
  one_active_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(q_active));

  // R1
  run_active_chk: assert property (@(posedge clk) disable iff (rst)
    run_valid |-> q_active[run_queue] && $countones(q_active) == 1);

  // R4
  save_after_drop_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_we |-> q_active == '0);

  // R5
  restore_inactive_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_we |-> q_active == '0);

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    switch_done |=> !switch_done);

  for (genvar g = 0; g < NQ; g++) begin : g_mapchk
    // R2
    mapped_only_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(q_active[g]) |-> $past(map_mask[g]));
  end
endmodule

// File: tb/ctxsw_pipe_bench.sv
module ctxsw_pipe_bench;
  localparam int NQ = 3;
  localparam int DW = 8;
  localparam int XW = 32;
  localparam int QW = 2;
  localparam int AW = 5;
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst = 1'b1;
  logic [NQ-1:0]    map_mask = '0;
  logic             sw_stream = 0, sw_sched = 0, pkt_boundary = 0, pkt_sw_en = 0;
  logic             pipe_idle = 1'b1;
  logic             mem_req_valid, mem_req_we, mem_req_ready = 1'b1;
  logic [AW-1:0]    mem_req_addr;
  logic [XW-1:0]    mem_req_wdata, mem_rsp_rdata;
  logic             mem_rsp_valid;
  logic             run_valid, switch_done;
  logic [QW-1:0]    run_queue;
  logic [DW*XW-1:0] run_desc;
  logic [NQ-1:0]    q_active;

  ctxsw_pipe #(.NQ(NQ), .DW(DW), .XW(XW)) u_ctxsw_pipe (.*);

  int checks = 0, fails = 0, wr_cnt = 0, cyc = 0;
  logic [XW-1:0] mem [NQ*DW];
  logic [XW-1:0] cnt [NQ];
  logic          rsp_v = 1'b0;
  logic [XW-1:0] rsp_d = '0;
  assign mem_rsp_valid = rsp_v;
  assign mem_rsp_rdata = rsp_d;

  function automatic logic [XW-1:0] pre_word(int q, int w);
    return (w == 1) ? XW'(q * 100) : (32'h5A00_0000 | XW'(q << 8) | XW'(w));
  endfunction

  function automatic int rr_next(int cur, logic [NQ-1:0] m, bit skip);
    for (int k = 1; k <= NQ; k++) begin
      int i = (cur + k) % NQ;
      if (m[i] && !(skip && i == cur)) return i;
    end
    return -1;
  endfunction

  // behavioural save area
  always @(posedge clk) begin
    cyc <= cyc + 1;
    rsp_v <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[mem_req_addr] <= mem_req_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rsp_v <= 1'b1;
        rsp_d <= mem[mem_req_addr];
      end
    end
  end

  always @(negedge clk) mem_req_ready <= ($urandom % 4) != 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_desc(input int q, input string tag);
    int bad = -1;
    for (int w = 0; w < DW; w++) begin
      logic [XW-1:0] e = (w == 1) ? cnt[q] : pre_word(q, w);
      if (run_desc[w*XW +: XW] !== e && bad < 0) bad = w;
    end
    if (bad < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, tag, run_desc[bad*XW +: XW], (bad == 1) ? cnt[q] : pre_word(q, bad));
  endtask

  task automatic check_slot(input int q, input string tag);
    int bad = -1;
    for (int w = 0; w < DW; w++) begin
      logic [XW-1:0] e = (w == 1) ? cnt[q] : pre_word(q, w);
      if (mem[q*DW+w] !== e && bad < 0) bad = w;
    end
    if (bad < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, tag, mem[q*DW+bad], (bad == 1) ? cnt[q] : pre_word(q, bad));
  endtask

  task automatic wait_switch(input string tag);
    bit seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (switch_done) seen = 1;
    end
    chk(seen, tag, 32'(seen), 1);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_pkt();
    pkt_boundary = 1'b1;
    @(negedge clk);
    pkt_boundary = 1'b0;
  endtask

  always @(posedge clk) begin
    if (cyc == WDOG) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int w0, exp_cur, prev;
    void'($urandom(32'd2024));
    for (int q = 0; q < NQ; q++) begin
      cnt[q] = XW'(q * 100);
      for (int w = 0; w < DW; w++) mem[q*DW+w] = pre_word(q, w);
    end
    idle_cycles(4);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!run_valid, "R11 run_valid", 32'(run_valid), 0);
    chk(q_active == 0, "R11 q_active", 32'(q_active), 0);
    chk(!mem_req_valid, "R11 mem_req_valid", 32'(mem_req_valid), 0);

    // R2 nothing mapped stays idle
    idle_cycles(10);
    chk(!run_valid && q_active == 0, "R2 idle with empty mask", 32'(q_active), 0);

    // R5 first activation restores queue 0
    w0 = wr_cnt;
    map_mask = 3'b001;
    wait_switch("R11 first activation");
    chk(run_queue == 0, "R11 first queue", 32'(run_queue), 0);
    chk(q_active == 3'b001, "R1 active bit", 32'(q_active), 1);
    check_desc(0, "R5 restored image q0");
    chk(wr_cnt == w0, "R5 restore issues no writes", wr_cnt, w0);

    // R6 packet counter
    for (int i = 0; i < 3; i++) begin pulse_pkt(); cnt[0]++; end
    @(negedge clk);
    chk(run_desc[XW +: XW] == cnt[0], "R6 packet count", run_desc[XW +: XW], cnt[0]);

    // R9 lone queue keeps running
    w0 = wr_cnt;
    sw_sched = 1'b1; @(negedge clk); sw_sched = 1'b0;
    idle_cycles(30);
    chk(run_valid && run_queue == 0, "R9 still running q0", 32'(run_queue), 0);
    chk(wr_cnt == w0, "R9 no save", wr_cnt, w0);

    // R4 drain gating, R8 skip of unmapped slot, R7 save image
    map_mask = 3'b101;
    pipe_idle = 1'b0;
    sw_sched = 1'b1; @(negedge clk); sw_sched = 1'b0;
    idle_cycles(20);
    chk(wr_cnt == w0, "R4 no save before drain", wr_cnt, w0);
    chk(q_active == 0 && !run_valid, "R4 active bit dropped", 32'(q_active), 0);
    pipe_idle = 1'b1;
    wait_switch("R3 sched switch");
    chk(run_queue == 2, "R8 round robin skip", 32'(run_queue), 2);
    check_slot(0, "R7 saved image q0");
    check_desc(2, "R5 restored image q2");

    // R3 packet trigger gated by pkt_sw_en
    pkt_sw_en = 1'b0;
    pulse_pkt(); cnt[2]++;
    idle_cycles(20);
    chk(run_valid && run_queue == 2, "R3 packet ignored when disabled", 32'(run_queue), 2);
    pkt_sw_en = 1'b1;
    pulse_pkt(); cnt[2]++;
    pkt_sw_en = 1'b0;
    wait_switch("R3 packet switch");
    chk(run_queue == 0, "R3 packet switch target", 32'(run_queue), 0);
    check_slot(2, "R7 saved image q2");
    check_desc(0, "R5 restored image q0 again");

    // R10 second request arriving during a switch
    sw_stream = 1'b1; @(negedge clk); sw_stream = 1'b0;
    sw_sched = 1'b1; @(negedge clk); sw_sched = 1'b0;
    wait_switch("R3 stream switch");
    chk(run_queue == 2, "R3 stream target", 32'(run_queue), 2);
    wait_switch("R10 pending switch");
    chk(run_queue == 0, "R10 pending target", 32'(run_queue), 0);

    // R12 unmap running queue with a successor, then with none
    map_mask = 3'b100;
    wait_switch("R12 forced switch");
    chk(run_queue == 2, "R12 forced target", 32'(run_queue), 2);
    check_slot(0, "R12 forced save q0");
    map_mask = 3'b000;
    idle_cycles(60);
    chk(!run_valid && q_active == 0, "R12 idle after last unmap", 32'(q_active), 0);
    check_slot(2, "R12 forced save q2");

    // random traffic, all queues mapped
    map_mask = 3'b111;
    exp_cur = rr_next(2, 3'b111, 1'b0);
    wait_switch("R8 wake from idle");
    chk(run_queue == QW'(exp_cur), "R8 wake target", 32'(run_queue), 32'(exp_cur));
    check_desc(exp_cur, "R5 wake image");
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      sw_sched = 1'b0;
      pkt_boundary = 1'b0;
      chk($countones(q_active) <= 1, "R1 single active", 32'(q_active), 0);
      if (switch_done) begin
        prev = exp_cur;
        exp_cur = rr_next(prev, map_mask, 1'b1);
        chk(run_queue == QW'(exp_cur), "R8 random target", 32'(run_queue), 32'(exp_cur));
        chk(q_active == NQ'(1 << exp_cur), "R1 random active", 32'(q_active), 32'(1 << exp_cur));
        check_slot(prev, "R7 random save");
        check_desc(exp_cur, "R6 random restore");
      end
      pipe_idle = ($urandom % 4) != 0;
      if (run_valid) begin
        if ($urandom % 4 == 0) begin pkt_boundary = 1'b1; cnt[exp_cur]++; end
        if ($urandom % 40 == 0) sw_sched = 1'b1;
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule